// File: doc/BRIEF.md
# Configuration Header Register File

This block keeps the 64-byte type-0 configuration header of a single bus function and answers byte, halfword and word accesses from a configuration access port. Each request carries an offset, a size code, a write flag and write data. The response comes back one cycle later and carries read data and three error flags. Vendor, device, class, revision, header type, subsystem and interrupt-pin fields are fixed by parameters. Command, interrupt line, cache line size and latency timer are programmable. The six base address registers support size discovery. An expansion ROM base register has its own sizing pattern.

When software gives a base address register a non-zero base, the block raises a one-cycle pulse on that register's line of `barChanged`. A companion address decoder uses that pulse together with the live register values on `barBaseFlat` to update its windows. Offsets 0x40 and above are not implemented and are refused. Each field has a fixed set of access sizes at which it accepts writes.

Top module: `cfg_hdr_regfile`

## Requirements
- R1: After reset, reads return the parameter identity fields. The command register reads 0. Each base address register reads its parameter start value, whose bit 0 selects I/O space (1) or memory space (0).
- R2: A request at offset 0x40 or above raises `errBeyond` with the response, returns read data 0 and changes no state.
- R3: A halfword request at an odd offset, a word request at an offset that is not a multiple of 4, or size code 3 raises `errAlign` and changes no state. Size codes are 0 = byte, 1 = halfword, 2 = word.
- R4: Every request produces exactly one response cycle, with `rspValid` high in the cycle after the request, and no response appears without a request.
- R5: Reads are little-endian. A read at offset N returns the byte at N in bits 7:0, the byte at N+1 in bits 15:8, and so on up to the access size. Bits above the access size are 0.
- R6: Byte writes at 0x3C (interrupt line), 0x0C (cache line size) and 0x0D (latency timer) change only the addressed byte.
- R7: Byte writes at 0x3D, 0x3E, 0x3F (interrupt pin, minimum grant, maximum latency) and at 0x08 to 0x0B (revision and class code) have no effect and raise no error.
- R8: The command register at 0x04 accepts halfword and word writes. A word write stores bits 15:0 and leaves the status halfword unchanged.
- R9: Any other write has no effect and raises `errRoWrite`. At most one error flag is high in a response.
- R10: A word write of 0xFFFFFFFF to a base address register at 0x10 + 4*i stores ~(size_i - 1) in its writable bits and keeps its type bits. The type bits are bits 1:0 in I/O space and bits 3:0 in memory space. Sizing raises no change pulse.
- R11: Any other word write to a base address register stores the written value in the writable bits and keeps the type bits. If the stored writable part is non-zero, `barChanged[i]` pulses for one cycle together with the response. `barBaseFlat[32*i+31:32*i]` always shows register i.
- R12: A word write of 0xFFFFFFFE to the expansion ROM register at 0x30 makes it read 0xFFFFFFFF. Any other word value is stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | 8 | Byte offset into configuration space |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqWrData | input | 32 | Write data, right-aligned |
| rspValid | output | 1 | Response strobe, one cycle after request |
| rspRdData | output | 32 | Read data, right-aligned |
| errBeyond | output | 1 | Offset outside the header |
| errAlign | output | 1 | Misaligned access or bad size code |
| errRoWrite | output | 1 | Write to a location not writable at that size |
| barChanged | output | 6 | One-cycle pulse per base register given a new base |
| barBaseFlat | output | 192 | Current value of the six base registers |

## Verification
Two things can happen in the same cycle. A base register write raises its change pulse in the same cycle as its response. If the next request is a read of that same register, issued with no idle cycle in between, that read is sampled on the edge where the new value lands. The bench provokes this with back-to-back requests: a programming write to a base register immediately followed by a read of it. It requires the pulse and the write's response to appear together. It requires the pulse to be gone in the read's response cycle, and the read to return the new value. A second back-to-back pair issues a sizing write followed at once by a read, and checks the sized value with no pulse.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int HDR_BYTES = 64;
  localparam int HDR_WORDS = HDR_BYTES / 4;
  localparam int NUM_BARS  = 6;
  localparam int OFFSET_W  = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_e;

  // header offsets the control decodes
  localparam logic [5:0] OFF_REVISION  = 6'h08;
  localparam logic [5:0] OFF_CLASS_HI  = 6'h0B;
  localparam logic [5:0] OFF_COMMAND   = 6'h04;
  localparam logic [5:0] OFF_CACHELINE = 6'h0C;
  localparam logic [5:0] OFF_LATENCY   = 6'h0D;
  localparam logic [5:0] OFF_BAR_FIRST = 6'h10;
  localparam logic [5:0] OFF_ROM       = 6'h30;
  localparam logic [5:0] OFF_INTLINE   = 6'h3C;
  localparam logic [5:0] OFF_INTPIN    = 6'h3D;
  localparam logic [5:0] OFF_MAXLAT    = 6'h3F;

  localparam logic [31:0] IO_TYPE_MASK  = 32'h0000_0003;
  localparam logic [31:0] MEM_TYPE_MASK = 32'h0000_000F;
  localparam logic [31:0] ROM_SIZE_PATTERN = 32'hFFFF_FFFE;

  typedef struct packed {
    logic                rdEn;
    logic                wrIntLine;
    logic                wrCacheLine;
    logic                wrLatency;
    logic                wrCommand;
    logic [NUM_BARS-1:0] wrBar;
    logic                wrRom;
    logic                errBeyond;
    logic                errAlign;
    logic                errRo;
  } ctrlStrobe_t;

endpackage

// File: rtl/cfg_hdr_ctrl.sv
module cfg_hdr_ctrl
  import cfg_hdr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [OFFSET_W-1:0] reqOffset,
  input  logic [1:0]          reqSize,
  output ctrlStrobe_t         strb,
  output logic                rspValid,
  output logic                errBeyond,
  output logic                errAlign,
  output logic                errRoWrite
);

  logic [5:0] off6;
  logic       beyond;
  logic       misaligned;
  logic       accOk;
  logic       byteWr;
  logic       halfWr;
  logic       wordWr;
  logic       silentByte;
  logic       anyTarget;

  assign off6   = reqOffset[5:0];
  assign beyond = reqOffset >= OFFSET_W'(HDR_BYTES);

  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = off6[0];
      SZ_WORD: misaligned = |off6[1:0];
      default: misaligned = 1'b1;
    endcase
  end

  assign accOk  = reqValid && !beyond && !misaligned;
  assign byteWr = accOk && reqWrite && (reqSize == SZ_BYTE);
  assign halfWr = accOk && reqWrite && (reqSize == SZ_HALF);
  assign wordWr = accOk && reqWrite && (reqSize == SZ_WORD);

  assign silentByte = ((off6 >= OFF_INTPIN) && (off6 <= OFF_MAXLAT)) ||
                      ((off6 >= OFF_REVISION) && (off6 <= OFF_CLASS_HI));

  for (genvar i = 0; i < NUM_BARS; i++) begin : g_barDec
    assign strb.wrBar[i] = wordWr && (off6 == OFF_BAR_FIRST + 6'(4 * i));
  end

  always_comb begin
    strb.rdEn        = accOk && !reqWrite;
    strb.wrIntLine   = byteWr && (off6 == OFF_INTLINE);
    strb.wrCacheLine = byteWr && (off6 == OFF_CACHELINE);
    strb.wrLatency   = byteWr && (off6 == OFF_LATENCY);
    strb.wrCommand   = (halfWr || wordWr) && (off6 == OFF_COMMAND);
    strb.wrRom       = wordWr && (off6 == OFF_ROM);
    strb.errBeyond   = reqValid && beyond;
    strb.errAlign    = reqValid && !beyond && misaligned;
    anyTarget = strb.wrIntLine || strb.wrCacheLine || strb.wrLatency ||
                strb.wrCommand || strb.wrRom || (|strb.wrBar) ||
                (byteWr && silentByte);
    strb.errRo       = accOk && reqWrite && !anyTarget;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      errBeyond  <= 1'b0;
      errAlign   <= 1'b0;
      errRoWrite <= 1'b0;
    end else begin
      rspValid   <= reqValid;
      errBeyond  <= strb.errBeyond;
      errAlign   <= strb.errAlign;
      errRoWrite <= strb.errRo;
    end
  end

endmodule

// File: rtl/cfg_hdr_datapath.sv
module cfg_hdr_datapath
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'hABCD,
  parameter logic [15:0] DEVICE_ID     = 16'h0123,
  parameter logic [15:0] STATUS_VALUE  = 16'h0000,
  parameter logic [7:0]  REVISION      = 8'h02,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [7:0]  HEADER_TYPE   = 8'h00,
  parameter logic [15:0] SUBSYS_VENDOR = 16'h5A5A,
  parameter logic [15:0] SUBSYS_ID     = 16'hA5A5,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [7:0]  MIN_GRANT     = 8'h10,
  parameter logic [7:0]  MAX_LATENCY   = 8'h20,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE =
    {32'h0, 32'h0, 32'h0, 32'h0010_0000, 32'h0000_1000, 32'h0000_0100},
  parameter logic [NUM_BARS-1:0][31:0] BAR_INIT =
    {32'h0, 32'h0, 32'h0, 32'h0000_0008, 32'h0000_0000, 32'h0000_0001}
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strb,
  input  logic [5:0]             accOffset,
  input  logic [1:0]             accSize,
  input  logic [31:0]            wrData,
  output logic [31:0]            rspRdData,
  output logic [NUM_BARS-1:0]    barChanged,
  output logic [NUM_BARS*32-1:0] barBaseFlat
);

  logic [7:0]  intLineQ;
  logic [7:0]  cacheLineQ;
  logic [7:0]  latencyQ;
  logic [15:0] commandQ;
  logic [31:0] romQ;
  logic [31:0] barQ    [NUM_BARS];
  logic [31:0] barNext [NUM_BARS];
  logic [NUM_BARS-1:0] announce;
  logic [31:0] hdrWord [HDR_WORDS];
  logic [31:0] shifted;
  logic [31:0] sizeMask;
  logic        sizingWrite;

  assign sizingWrite = (wrData == 32'hFFFF_FFFF);

  // per-register base update and change detection
  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    logic [31:0] typeMask;
    logic [31:0] sizedBits;
    logic [31:0] keptType;
    assign typeMask  = barQ[i][0] ? IO_TYPE_MASK : MEM_TYPE_MASK;
    assign sizedBits = ~(BAR_SIZE[i] - 32'd1);
    assign keptType  = barQ[i] & typeMask;
    assign barNext[i] = sizingWrite ? ((sizedBits & ~typeMask) | keptType)
                                    : ((wrData & ~typeMask) | keptType);
    assign announce[i] = strb.wrBar[i] && !sizingWrite &&
                         ((wrData & ~typeMask) != 32'd0);
    assign barBaseFlat[32*i +: 32] = barQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BARS; i++) barQ[i] <= BAR_INIT[i];
      barChanged <= '0;
    end else begin
      for (int i = 0; i < NUM_BARS; i++) begin
        if (strb.wrBar[i]) barQ[i] <= barNext[i];
      end
      barChanged <= announce;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intLineQ   <= 8'h00;
      cacheLineQ <= 8'h00;
      latencyQ   <= 8'h00;
      commandQ   <= 16'h0000;
      romQ       <= 32'h0000_0000;
    end else begin
      if (strb.wrIntLine)   intLineQ   <= wrData[7:0];
      if (strb.wrCacheLine) cacheLineQ <= wrData[7:0];
      if (strb.wrLatency)   latencyQ   <= wrData[7:0];
      if (strb.wrCommand)   commandQ   <= wrData[15:0];
      if (strb.wrRom)       romQ <= (wrData == ROM_SIZE_PATTERN) ? 32'hFFFF_FFFF : wrData;
    end
  end

  // little-endian word image of the header
  always_comb begin
    for (int w = 0; w < HDR_WORDS; w++) hdrWord[w] = 32'd0;
    hdrWord[0]  = {DEVICE_ID, VENDOR_ID};
    hdrWord[1]  = {STATUS_VALUE, commandQ};
    hdrWord[2]  = {CLASS_CODE, REVISION};
    hdrWord[3]  = {8'h00, HEADER_TYPE, latencyQ, cacheLineQ};
    for (int i = 0; i < NUM_BARS; i++) hdrWord[4 + i] = barQ[i];
    hdrWord[11] = {SUBSYS_ID, SUBSYS_VENDOR};
    hdrWord[12] = romQ;
    hdrWord[15] = {MAX_LATENCY, MIN_GRANT, INT_PIN, intLineQ};
  end

  always_comb begin
    unique case (accSize_e'(accSize))
      SZ_BYTE: sizeMask = 32'h0000_00FF;
      SZ_HALF: sizeMask = 32'h0000_FFFF;
      default: sizeMask = 32'hFFFF_FFFF;
    endcase
  end

  assign shifted = hdrWord[accOffset[5:2]] >> {accOffset[1:0], 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) rspRdData <= 32'd0;
    else       rspRdData <= strb.rdEn ? (shifted & sizeMask) : 32'd0;
  end

endmodule

// File: rtl/cfg_hdr_regfile.sv
module cfg_hdr_regfile
  import cfg_hdr_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'hABCD,
  parameter logic [15:0] DEVICE_ID     = 16'h0123,
  parameter logic [7:0]  REVISION      = 8'h02,
  parameter logic [23:0] CLASS_CODE    = 24'h020000,
  parameter logic [7:0]  INT_PIN       = 8'h01,
  parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE =
    {32'h0, 32'h0, 32'h0, 32'h0010_0000, 32'h0000_1000, 32'h0000_0100},
  parameter logic [NUM_BARS-1:0][31:0] BAR_INIT =
    {32'h0, 32'h0, 32'h0, 32'h0000_0008, 32'h0000_0000, 32'h0000_0001}
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic [7:0]   reqOffset,
  input  logic [1:0]   reqSize,
  input  logic [31:0]  reqWrData,
  output logic         rspValid,
  output logic [31:0]  rspRdData,
  output logic         errBeyond,
  output logic         errAlign,
  output logic         errRoWrite,
  output logic [5:0]   barChanged,
  output logic [191:0] barBaseFlat
);

  ctrlStrobe_t strb;

  cfg_hdr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqOffset  (reqOffset),
    .reqSize    (reqSize),
    .strb       (strb),
    .rspValid   (rspValid),
    .errBeyond  (errBeyond),
    .errAlign   (errAlign),
    .errRoWrite (errRoWrite)
  );

  cfg_hdr_datapath #(
    .VENDOR_ID  (VENDOR_ID),
    .DEVICE_ID  (DEVICE_ID),
    .REVISION   (REVISION),
    .CLASS_CODE (CLASS_CODE),
    .INT_PIN    (INT_PIN),
    .BAR_SIZE   (BAR_SIZE),
    .BAR_INIT   (BAR_INIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .accOffset   (reqOffset[5:0]),
    .accSize     (reqSize),
    .wrData      (reqWrData),
    .rspRdData   (rspRdData),
    .barChanged  (barChanged),
    .barBaseFlat (barBaseFlat)
  );

endmodule

// File: rtl/cfg_hdr_checker.sv
module cfg_hdr_checker (
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic         reqWrite,
  input logic [7:0]   reqOffset,
  input logic [1:0]   reqSize,
  input logic [31:0]  reqWrData,
  input logic         rspValid,
  input logic [31:0]  rspRdData,
  input logic         errBeyond,
  input logic         errAlign,
  input logic         errRoWrite,
  input logic [5:0]   barChanged,
  input logic [191:0] barBaseFlat
);

  logic anyErr;
  assign anyErr = errBeyond || errAlign || errRoWrite;

  assert_rsp_follows_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_no_spurious_rsp_R4: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_beyond_flagged_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOffset >= 8'h40) |=> errBeyond);

  assert_beyond_no_data_R2: assert property (@(posedge clk) disable iff (!rstN)
    errBeyond |-> (rspRdData == 32'd0));

  assert_err_with_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |-> rspValid);

  assert_err_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errBeyond, errAlign, errRoWrite}));

  assert_err_keeps_bars_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyErr |-> $stable(barBaseFlat));

  assert_change_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(barChanged));

  assert_change_from_word_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (barChanged != 6'd0) |-> $past(reqValid && reqWrite && reqSize == 2'd2 &&
                                   reqWrData != 32'hFFFF_FFFF));

endmodule

bind cfg_hdr_regfile cfg_hdr_checker u_chk (.*);

// File: tb/tb_cfg_hdr_regfile.sv
`timescale 1ns/1ps
module tb_cfg_hdr_regfile;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [7:0]   reqOffset = 8'd0;
  logic [1:0]   reqSize = 2'd0;
  logic [31:0]  reqWrData = 32'd0;
  logic         rspValid;
  logic [31:0]  rspRdData;
  logic         errBeyond;
  logic         errAlign;
  logic         errRoWrite;
  logic [5:0]   barChanged;
  logic [191:0] barBaseFlat;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // captured response of the most recent access
  logic        cVld;
  logic [31:0] cData;
  logic [2:0]  cErr;   // {beyond, align, roWrite}
  logic [5:0]  cChg;

  cfg_hdr_regfile dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic [7:0] off, input logic [1:0] sz,
                       input logic [31:0] wd);
    reqValid = 1'b1; reqWrite = wr; reqOffset = off; reqSize = sz; reqWrData = wd;
  endtask

  task automatic capture();
    cVld = rspValid; cData = rspRdData;
    cErr = {errBeyond, errAlign, errRoWrite}; cChg = barChanged;
  endtask

  task automatic access(input logic wr, input logic [7:0] off, input logic [1:0] sz,
                        input logic [31:0] wd);
    @(negedge clk);
    drive(wr, off, sz, wd);
    @(negedge clk);
    capture();
    reqValid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] off, input logic [1:0] sz);
    access(1'b0, off, sz, 32'd0);
  endtask

  task automatic wr(input logic [7:0] off, input logic [1:0] sz, input logic [31:0] wd);
    access(1'b1, off, sz, wd);
  endtask

  task automatic t_reset();
    chk("R4 idle rspValid after reset", {31'd0, rspValid}, 32'd0);
    rd(8'h00, 2'd2); chk("R1 id word", cData, 32'h0123_ABCD);
    rd(8'h04, 2'd2); chk("R1 command/status", cData, 32'h0000_0000);
    rd(8'h10, 2'd2); chk("R1 bar0 init", cData, 32'h0000_0001);
    rd(8'h18, 2'd2); chk("R1 bar2 init", cData, 32'h0000_0008);
    chk("R4 response strobe", {31'd0, cVld}, 32'd1);
  endtask

  task automatic t_readSizes();
    rd(8'h01, 2'd0); chk("R5 byte at 1", cData, 32'h0000_00AB);
    rd(8'h02, 2'd1); chk("R5 half at 2", cData, 32'h0000_0123);
    rd(8'h08, 2'd2); chk("R5 class word", cData, 32'h0200_0002);
    rd(8'h0A, 2'd1); chk("R5 half at A", cData, 32'h0000_0200);
    rd(8'h3D, 2'd0); chk("R5 int pin byte", cData, 32'h0000_0001);
  endtask

  task automatic t_byteWrites();
    wr(8'h3C, 2'd0, 32'hFFFF_FF0B); chk("R6 no error", {29'd0, cErr}, 32'd0);
    wr(8'h0C, 2'd0, 32'h0000_0010);
    wr(8'h0D, 2'd0, 32'h0000_0040);
    rd(8'h0C, 2'd2); chk("R6 cache/latency word", cData, 32'h0000_4010);
    rd(8'h3C, 2'd2); chk("R6 int line word", cData, 32'h2010_010B);
  endtask

  task automatic t_silent();
    wr(8'h3D, 2'd0, 32'h0000_00EE); chk("R7 int pin no error", {29'd0, cErr}, 32'd0);
    wr(8'h3F, 2'd0, 32'h0000_0055); chk("R7 max lat no error", {29'd0, cErr}, 32'd0);
    wr(8'h08, 2'd0, 32'h0000_0077); chk("R7 revision no error", {29'd0, cErr}, 32'd0);
    wr(8'h0A, 2'd0, 32'h0000_0099);
    rd(8'h3C, 2'd2); chk("R7 int word unchanged", cData, 32'h2010_010B);
    rd(8'h08, 2'd2); chk("R7 class word unchanged", cData, 32'h0200_0002);
  endtask

  task automatic t_command();
    wr(8'h04, 2'd1, 32'h0000_0007); chk("R8 half no error", {29'd0, cErr}, 32'd0);
    rd(8'h04, 2'd2); chk("R8 half write", cData, 32'h0000_0007);
    wr(8'h04, 2'd2, 32'hFFFF_0146);
    rd(8'h04, 2'd2); chk("R8 word write keeps status", cData, 32'h0000_0146);
  endtask

  task automatic t_roErr();
    wr(8'h00, 2'd2, 32'h1111_2222); chk("R9 id write flagged", {29'd0, cErr}, 32'd1);
    rd(8'h00, 2'd2); chk("R9 id unchanged", cData, 32'h0123_ABCD);
    wr(8'h0C, 2'd1, 32'h0000_7777); chk("R9 half at C flagged", {29'd0, cErr}, 32'd1);
    wr(8'h0E, 2'd0, 32'h0000_0080); chk("R9 header type flagged", {29'd0, cErr}, 32'd1);
    rd(8'h0C, 2'd2); chk("R9 word C unchanged", cData, 32'h0000_4010);
  endtask

  task automatic t_beyond();
    rd(8'h40, 2'd2); chk("R2 read flagged", {29'd0, cErr}, 32'd4);
    chk("R2 read data zero", cData, 32'd0);
    wr(8'h44, 2'd2, 32'h0000_0000); chk("R2 write flagged", {29'd0, cErr}, 32'd4);
    wr(8'hFC, 2'd0, 32'h0000_0000); chk("R2 high byte flagged", {29'd0, cErr}, 32'd4);
    rd(8'h04, 2'd2); chk("R2 command unchanged", cData, 32'h0000_0146);
  endtask

  task automatic t_align();
    rd(8'h01, 2'd1); chk("R3 odd half flagged", {29'd0, cErr}, 32'd2);
    chk("R3 odd half data zero", cData, 32'd0);
    wr(8'h12, 2'd2, 32'h0000_C000); chk("R3 word at 12 flagged", {29'd0, cErr}, 32'd2);
    wr(8'h04, 2'd3, 32'h0000_0000); chk("R3 bad size flagged", {29'd0, cErr}, 32'd2);
    rd(8'h10, 2'd2); chk("R3 bar0 unchanged", cData, 32'h0000_0001);
    rd(8'h04, 2'd2); chk("R3 command unchanged", cData, 32'h0000_0146);
  endtask

  task automatic t_barSizing();
    wr(8'h10, 2'd2, 32'hFFFF_FFFF); chk("R10 io sizing no pulse", {26'd0, cChg}, 32'd0);
    rd(8'h10, 2'd2); chk("R10 io bar sized", cData, 32'hFFFF_FF01);
    wr(8'h14, 2'd2, 32'hFFFF_FFFF);
    rd(8'h14, 2'd2); chk("R10 mem bar sized", cData, 32'hFFFF_F000);
    wr(8'h18, 2'd2, 32'hFFFF_FFFF);
    rd(8'h18, 2'd2); chk("R10 prefetch type kept", cData, 32'hFFF0_0008);
    wr(8'h1C, 2'd2, 32'hFFFF_FFFF);
    rd(8'h1C, 2'd2); chk("R10 zero-size bar", cData, 32'h0000_0000);
  endtask

  task automatic t_barProgram();
    wr(8'h10, 2'd2, 32'h0000_C002); chk("R11 io pulse", {26'd0, cChg}, 32'h01);
    chk("R11 io base on port", barBaseFlat[31:0], 32'h0000_C001);
    @(negedge clk); chk("R11 pulse one cycle", {26'd0, barChanged}, 32'd0);
    wr(8'h14, 2'd2, 32'h8000_000F); chk("R11 mem pulse", {26'd0, cChg}, 32'h02);
    rd(8'h14, 2'd2); chk("R11 mem type bits kept", cData, 32'h8000_0000);
    wr(8'h14, 2'd2, 32'h0000_0005); chk("R11 zero base no pulse", {26'd0, cChg}, 32'd0);
    rd(8'h14, 2'd2); chk("R11 zero base stored", cData, 32'h0000_0000);
  endtask

  task automatic t_rom();
    wr(8'h30, 2'd2, 32'hFFFF_FFFE);
    rd(8'h30, 2'd2); chk("R12 rom sizing", cData, 32'hFFFF_FFFF);
    wr(8'h30, 2'd2, 32'h000C_0001);
    rd(8'h30, 2'd2); chk("R12 rom stored", cData, 32'h000C_0001);
  endtask

  // write then read of the same base register with no idle cycle between
  task automatic t_backToBack();
    @(negedge clk);
    drive(1'b1, 8'h24, 2'd2, 32'h1234_5670);
    @(negedge clk);
    capture();
    chk("R11 b2b write pulse", {26'd0, cChg}, 32'h20);
    chk("R4 b2b write response", {31'd0, cVld}, 32'd1);
    drive(1'b0, 8'h24, 2'd2, 32'd0);
    @(negedge clk);
    capture();
    reqValid = 1'b0;
    chk("R11 b2b read sees new base", cData, 32'h1234_5670);
    chk("R11 b2b pulse gone", {26'd0, cChg}, 32'd0);
    @(negedge clk);
    drive(1'b1, 8'h10, 2'd2, 32'hFFFF_FFFF);
    @(negedge clk);
    capture();
    chk("R10 b2b sizing no pulse", {26'd0, cChg}, 32'd0);
    drive(1'b0, 8'h10, 2'd2, 32'd0);
    @(negedge clk);
    capture();
    reqValid = 1'b0;
    chk("R10 b2b sized value", cData, 32'hFFFF_FF01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readSizes();
    t_byteWrites();
    t_silent();
    t_command();
    t_roErr();
    t_beyond();
    t_align();
    t_barSizing();
    t_barProgram();
    t_rom();
    t_backToBack();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule